// File: doc/BRIEF.md
# Disk Transfer Start-Address Generator

This block turns the task-file addressing registers of a disk command into the byte offset where the transfer begins. It then steps that offset forward one block each time a block of data has been moved. A single `start_i` pulse samples the sector, cylinder and drive/head registers, along with the geometry of the selected drive. The block works out the address over a number of cycles, shows `busy_o` during the calculation, and raises `done_o` for one cycle when `byte_addr_o` and `addr_err_o` are valid.

Bit 6 of the drive/head register chooses between two addressing modes:

- **Linear mode:** the register fields are packed straight into a 28-bit block index.
- **Cylinder/head/sector mode:** the block index is computed from the drive's head count and sectors per track, with the sector field counted from one.

In both modes the index is multiplied by the drive's bytes-per-block value. All products come from one shared shift-and-add multiplier. The multiplier stops as soon as its remaining multiplier bits are zero.

The block does not decode commands and does not move data. It only supplies and advances the address.

Top module: `chs_lba_addr_gen`

## Requirements
- R1: After reset, `byte_addr_o` is 0 and `addr_err_o`, `busy_o` and `done_o` are all 0.
- R2: When `dev_head_i[6]` is 1, the block index is `{dev_head_i[3:0], cyl_hi_i, cyl_lo_i, sector_i}`. In this mode, a zero head count or a zero sectors-per-track value is not an error.
- R3: When `dev_head_i[6]` is 0, the block index is ((C × `head_count_i` + H) × `trk_sectors_i`) + S − 1, where:
  - C = `{cyl_hi_i, cyl_lo_i}`
  - H = `dev_head_i[3:0]`
  - S = `sector_i`, counted from one
- R4: With a drive attached and no error, the byte address is the block index multiplied by `blk_bytes_i`, and it fills all 48 bits of `byte_addr_o`.
- R5: In cylinder/head/sector mode, a `head_count_i` or `trk_sectors_i` of zero causes the following, reported with the `done_o` pulse:
  - `addr_err_o` is 1.
  - `byte_addr_o` is 0.
- R6: When `drive_present_i` is 0 at start, the following apply, whatever the other inputs are:
  - The address is 0.
  - There is no error.
  - The step size is 512 bytes.
- R7: A one-cycle `blk_adv_i` pulse while idle adds the current step size to `byte_addr_o`. The step size is the block size of the last command, or 512 for no drive. The pulse is ignored while `addr_err_o` is 1.
- R8: `done_o` rises no more than 40 clock edges after the edge that samples `start_i`, and it is high for exactly one cycle.
- R9: While `busy_o` is 1, a `start_i` or `blk_adv_i` pulse has no effect. `byte_addr_o` holds its value, and the result is computed from the inputs sampled at the original start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to compute a new start address |
| drive_present_i | input | 1 | A drive is attached to the selected position |
| dev_head_i | input | 8 | Drive/head register: bit 6 selects linear mode, bits 3:0 give the head number or the top index bits |
| sector_i | input | 8 | Sector number register |
| cyl_lo_i | input | 8 | Cylinder low register |
| cyl_hi_i | input | 8 | Cylinder high register |
| blk_bytes_i | input | BPB_W (16) | Bytes per block of the drive |
| trk_sectors_i | input | GEO_W (8) | Sectors per track of the drive |
| head_count_i | input | GEO_W (8) | Head count of the drive |
| blk_adv_i | input | 1 | One block has been transferred; advance the address |
| byte_addr_o | output | 16+2·GEO_W+BPB_W (48) | Current byte address |
| addr_err_o | output | 1 | The last command hit the zero-geometry error |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse: the result is valid |

## Verification
The bench builds the block with the default widths: 16-bit block sizes and 8-bit geometry. At these widths a 65535-byte block, 255 heads and 255 sectors per track can all be driven at the same time. This brings the slowest three-multiply path within reach, and with it the 40-edge bound and the full 48-bit result. Start and advance pulses are injected in the middle of a calculation, so the snapshot of the inputs and the hold on the address are observed at the ports. The zero-geometry, no-drive and zero-based stepping cases are run back to back so that the step size carried between commands is exercised.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEADS,
    ST_SPT,
    ST_SCALE
  } agen_st_e;

  localparam int DEF_BLK_BYTES = 512;
endpackage

// File: rtl/agen_mul.sv
// Shift-add multiplier, one multiplier bit per cycle, early exit when the
// remaining multiplier bits are zero. go_i reloads even while running.
module agen_mul #(
  parameter int A_W = 48,
  parameter int B_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           rdy_o,
  output logic [A_W-1:0] prod_o
);
  logic           run_q, run_d;
  logic [A_W-1:0] acc_q, acc_d;
  logic [A_W-1:0] mc_q, mc_d;
  logic [B_W-1:0] mp_q, mp_d;

  always_comb begin
    run_d = run_q;
    acc_d = acc_q;
    mc_d  = mc_q;
    mp_d  = mp_q;
    if (go_i) begin
      run_d = 1'b1;
      acc_d = '0;
      mc_d  = a_i;
      mp_d  = b_i;
    end else if (run_q) begin
      if (mp_q == '0) begin
        run_d = 1'b0;
      end else begin
        if (mp_q[0]) acc_d = acc_q + mc_q;
        mc_d = mc_q << 1;
        mp_d = mp_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else begin
      run_q <= run_d;
      acc_q <= acc_d;
      mc_q  <= mc_d;
      mp_q  <= mp_d;
    end
  end

  assign rdy_o  = run_q && (mp_q == '0);
  assign prod_o = acc_q;

  AST_MUL_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !go_i && mp_q != '0) |=> (mp_q < $past(mp_q))); // R8
endmodule

// File: rtl/agen_fsm.sv
// Sequences the multiplies for the two addressing modes and produces the
// value loaded into the address register.
module agen_fsm
  import agen_pkg::*;
#(
  parameter int BPB_W   = 16,
  parameter int GEO_W   = 8,
  parameter int ADDR_W  = 48,
  parameter int MB_W    = 16,
  parameter int MAX_LAT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              present_i,
  input  logic              lin_mode_i,
  input  logic [3:0]        head_i,
  input  logic [7:0]        sn_i,
  input  logic [7:0]        cl_i,
  input  logic [7:0]        ch_i,
  input  logic [BPB_W-1:0]  bpb_i,
  input  logic [GEO_W-1:0]  spt_i,
  input  logic [GEO_W-1:0]  heads_i,
  input  logic              mul_rdy_i,
  input  logic [ADDR_W-1:0] mul_prod_i,
  output logic              mul_go_o,
  output logic [ADDR_W-1:0] mul_a_o,
  output logic [MB_W-1:0]   mul_b_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] ld_addr_o,
  output logic [BPB_W-1:0]  ld_step_o,
  output logic              ld_err_o,
  output logic              busy_o
);
  localparam int LAT_W = $clog2(MAX_LAT + 1) + 1;

  agen_st_e         st_q, st_d;
  logic [3:0]       hd_q;
  logic [7:0]       sn_q;
  logic [GEO_W-1:0] spt_q;
  logic [BPB_W-1:0] bpb_q;
  logic             snap_en;
  logic [LAT_W-1:0] lat_q, lat_d;

  assign snap_en = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d      = st_q;
    mul_go_o  = 1'b0;
    mul_a_o   = '0;
    mul_b_o   = '0;
    load_o    = 1'b0;
    ld_addr_o = '0;
    ld_step_o = bpb_q;
    ld_err_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!present_i) begin
            load_o    = 1'b1;
            ld_step_o = BPB_W'(DEF_BLK_BYTES);
          end else if (lin_mode_i) begin
            mul_go_o = 1'b1;
            mul_a_o  = ADDR_W'({head_i, ch_i, cl_i, sn_i});
            mul_b_o  = MB_W'(bpb_i);
            st_d     = ST_SCALE;
          end else if (heads_i == '0 || spt_i == '0) begin
            load_o    = 1'b1;
            ld_err_o  = 1'b1;
            ld_step_o = bpb_i;
          end else begin
            mul_go_o = 1'b1;
            mul_a_o  = ADDR_W'({ch_i, cl_i});
            mul_b_o  = MB_W'(heads_i);
            st_d     = ST_HEADS;
          end
        end
      end
      ST_HEADS: begin
        if (mul_rdy_i) begin
          mul_go_o = 1'b1;
          mul_a_o  = mul_prod_i + ADDR_W'(hd_q);
          mul_b_o  = MB_W'(spt_q);
          st_d     = ST_SPT;
        end
      end
      ST_SPT: begin
        if (mul_rdy_i) begin
          mul_go_o = 1'b1;
          mul_a_o  = mul_prod_i + ADDR_W'(sn_q) - ADDR_W'(1);
          mul_b_o  = MB_W'(bpb_q);
          st_d     = ST_SCALE;
        end
      end
      ST_SCALE: begin
        if (mul_rdy_i) begin
          load_o    = 1'b1;
          ld_addr_o = mul_prod_i;
          ld_step_o = bpb_q;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign lat_d  = busy_o ? lat_q + LAT_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hd_q  <= '0;
      sn_q  <= '0;
      spt_q <= '0;
      bpb_q <= '0;
      lat_q <= '0;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
      if (snap_en) begin
        hd_q  <= head_i;
        sn_q  <= sn_i;
        spt_q <= spt_i;
        bpb_q <= bpb_i;
      end
    end
  end

  AST_DONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (lat_q < LAT_W'(MAX_LAT))); // R8
  AST_CHS_GEOMETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HEADS || st_q == ST_SPT) |-> (spt_q != '0)); // R5
endmodule

// File: rtl/agen_accum.sv
// Holds the current byte address, the step size and the error flag.
module agen_accum
  import agen_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int BPB_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [BPB_W-1:0]  ld_step_i,
  input  logic              ld_err_i,
  input  logic              adv_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BPB_W-1:0]  step_q, step_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              adv_en;

  assign adv_en = adv_i && !busy_i && !err_q;

  always_comb begin
    addr_d = addr_q;
    step_d = step_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (load_i) begin
      addr_d = ld_addr_i;
      step_d = ld_step_i;
      err_d  = ld_err_i;
      done_d = 1'b1;
    end else if (adv_en) begin
      addr_d = addr_q + ADDR_W'(step_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= BPB_W'(DEF_BLK_BYTES);
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      step_q <= step_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign err_o  = err_q;
  assign done_o = done_q;

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (addr_q == '0)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !load_i) |=> $stable(addr_q)); // R9
endmodule

// File: rtl/chs_lba_addr_gen.sv
module chs_lba_addr_gen #(
  parameter  int BPB_W  = 16,
  parameter  int GEO_W  = 8,
  localparam int ADDR_W = 16 + 2 * GEO_W + BPB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              drive_present_i,
  input  logic [7:0]        dev_head_i,
  input  logic [7:0]        sector_i,
  input  logic [7:0]        cyl_lo_i,
  input  logic [7:0]        cyl_hi_i,
  input  logic [BPB_W-1:0]  blk_bytes_i,
  input  logic [GEO_W-1:0]  trk_sectors_i,
  input  logic [GEO_W-1:0]  head_count_i,
  input  logic              blk_adv_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic              addr_err_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MB_W    = (BPB_W > GEO_W) ? BPB_W : GEO_W;
  localparam int MAX_LAT = 2 * GEO_W + BPB_W + 8;

  logic              mul_go, mul_rdy;
  logic [ADDR_W-1:0] mul_a, mul_prod;
  logic [MB_W-1:0]   mul_b;
  logic              load;
  logic [ADDR_W-1:0] ld_addr;
  logic [BPB_W-1:0]  ld_step;
  logic              ld_err;
  logic              unused_dh;

  assign unused_dh = ^{dev_head_i[7], dev_head_i[5:4]};

  agen_fsm #(
    .BPB_W(BPB_W), .GEO_W(GEO_W), .ADDR_W(ADDR_W),
    .MB_W(MB_W), .MAX_LAT(MAX_LAT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .present_i  (drive_present_i),
    .lin_mode_i (dev_head_i[6]),
    .head_i     (dev_head_i[3:0]),
    .sn_i       (sector_i),
    .cl_i       (cyl_lo_i),
    .ch_i       (cyl_hi_i),
    .bpb_i      (blk_bytes_i),
    .spt_i      (trk_sectors_i),
    .heads_i    (head_count_i),
    .mul_rdy_i  (mul_rdy),
    .mul_prod_i (mul_prod),
    .mul_go_o   (mul_go),
    .mul_a_o    (mul_a),
    .mul_b_o    (mul_b),
    .load_o     (load),
    .ld_addr_o  (ld_addr),
    .ld_step_o  (ld_step),
    .ld_err_o   (ld_err),
    .busy_o     (busy_o)
  );

  agen_mul #(.A_W(ADDR_W), .B_W(MB_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (mul_go),
    .a_i    (mul_a),
    .b_i    (mul_b),
    .rdy_o  (mul_rdy),
    .prod_o (mul_prod)
  );

  agen_accum #(.ADDR_W(ADDR_W), .BPB_W(BPB_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .ld_addr_i (ld_addr),
    .ld_step_i (ld_step),
    .ld_err_i  (ld_err),
    .adv_i     (blk_adv_i),
    .busy_i    (busy_o),
    .addr_o    (byte_addr_o),
    .err_o     (addr_err_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/sim_chs_lba_addr_gen.sv
`timescale 1ns/100ps
module sim_chs_lba_addr_gen;
  localparam int BPB_W = 16;
  localparam int GEO_W = 8;
  localparam int AW    = 16 + 2 * GEO_W + BPB_W;
  localparam longint MASK = (64'd1 << AW) - 1;

  typedef struct {
    longint addr;
    bit     err;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, present_i, adv_i;
  logic [7:0] dh_i, sn_i, cl_i, ch_i;
  logic [BPB_W-1:0] bpb_i;
  logic [GEO_W-1:0] spt_i, heads_i;
  logic [AW-1:0] addr_o;
  logic err_o, busy_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t sb[$];
  longint cur_addr;
  longint cur_step;
  bit     cur_err;

  always #2.5 clk = ~clk;

  chs_lba_addr_gen #(.BPB_W(BPB_W), .GEO_W(GEO_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .drive_present_i(present_i),
    .dev_head_i(dh_i), .sector_i(sn_i), .cyl_lo_i(cl_i), .cyl_hi_i(ch_i),
    .blk_bytes_i(bpb_i), .trk_sectors_i(spt_i), .head_count_i(heads_i),
    .blk_adv_i(adv_i), .byte_addr_o(addr_o), .addr_err_o(err_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done_o === 1'b1) begin
      if (sb.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " addr"}, longint'(addr_o), e.addr);
        chk({e.tag, " err"}, longint'(err_o), longint'(e.err));
      end
    end
  end

  // Driver: computes the expected result, pushes it, then issues start.
  task automatic run_cmd(string tag, bit pres, logic [7:0] dh, logic [7:0] sn,
                         logic [7:0] cl, logic [7:0] ch, int bpb, int spt,
                         int hcnt, bit inject);
    exp_t e;
    longint blk;
    int step;
    int n;
    e.err = 1'b0;
    e.tag = tag;
    step  = bpb;
    if (!pres) begin
      e.addr = 0;
      step   = 512;
    end else if (dh[6]) begin
      blk    = longint'({dh[3:0], ch, cl, sn});
      e.addr = (blk * bpb) & MASK;
    end else if (spt == 0 || hcnt == 0) begin
      e.addr = 0;
      e.err  = 1'b1;
    end else begin
      blk    = (longint'({ch, cl}) * hcnt + longint'(dh[3:0])) * spt + longint'(sn) - 1;
      e.addr = (blk * bpb) & MASK;
    end
    sb.push_back(e);
    @(posedge clk); #1;
    present_i = pres; dh_i = dh; sn_i = sn; cl_i = cl; ch_i = ch;
    bpb_i = BPB_W'(bpb); spt_i = GEO_W'(spt); heads_i = GEO_W'(hcnt);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (inject && n == 2) begin
        adv_i = 1'b1; start_i = 1'b1; sn_i = sn + 8'd7;
      end
      if (inject && n == 3) begin
        adv_i = 1'b0; start_i = 1'b0;
        chk("R9 addr held while busy", longint'(addr_o), cur_addr);
      end
      if (done_o === 1'b1) break;
      if (n > 60) break;
    end
    chk("R8 done within 40 edges", longint'(n <= 40), 1);
    @(negedge clk);
    chk("R8 done single cycle", longint'(done_o), 0);
    cur_addr = e.addr;
    cur_err  = e.err;
    cur_step = step;
  endtask

  task automatic advance(string tag);
    @(posedge clk); #1;
    adv_i = 1'b1;
    @(posedge clk); #1;
    adv_i = 1'b0;
    if (!cur_err) cur_addr = (cur_addr + cur_step) & MASK;
    @(negedge clk);
    chk(tag, longint'(addr_o), cur_addr);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R8 watchdog expired: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; adv_i = 1'b0; present_i = 1'b0;
    dh_i = '0; sn_i = '0; cl_i = '0; ch_i = '0;
    bpb_i = '0; spt_i = '0; heads_i = '0;
    cur_addr = 0; cur_step = 512; cur_err = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", longint'(addr_o), 0);
    chk("R1 err", longint'(err_o), 0);
    chk("R1 busy", longint'(busy_o), 0);
    chk("R1 done", longint'(done_o), 0);

    // R2 / R4 linear packing, 512-byte blocks
    run_cmd("R2 lin basic", 1, 8'h45, 8'h56, 8'h34, 8'h12, 512, 63, 16, 0);
    advance("R7 advance 1");
    advance("R7 advance 2");
    // R2 zero geometry is fine in linear mode, R4 2048-byte block, top bits
    run_cmd("R2 lin zero geo", 1, 8'h5F, 8'hFF, 8'hFF, 8'hFF, 2048, 0, 0, 0);
    // R4 odd block size
    run_cmd("R4 lin odd bpb", 1, 8'hC3, 8'h01, 8'h00, 8'h80, 1000, 1, 1, 0);
    // R3 cylinder/head/sector
    run_cmd("R3 chs basic", 1, 8'h03, 8'h01, 8'h02, 8'h01, 512, 63, 16, 0);
    advance("R7 advance chs");
    run_cmd("R3 chs mid", 1, 8'h1A, 8'h20, 8'h9C, 8'h03, 4096, 17, 12, 0);
    // R8 slowest path, R4 full-width result
    run_cmd("R8 chs worst", 1, 8'h0F, 8'hFF, 8'hFF, 8'hFF, 65535, 255, 255, 0);
    // R5 zero geometry in cylinder mode
    run_cmd("R5 heads zero", 1, 8'h02, 8'h05, 8'h10, 8'h00, 512, 63, 0, 0);
    advance("R7 advance ignored on err");
    run_cmd("R5 spt zero", 1, 8'h02, 8'h05, 8'h10, 8'h00, 512, 0, 4, 0);
    // R6 no drive
    run_cmd("R6 no drive", 0, 8'h4F, 8'h77, 8'h66, 8'h55, 4096, 9, 9, 0);
    advance("R6 step is 512");
    // R9 start and advance mid-calculation ignored
    run_cmd("R9 inject lin", 1, 8'h41, 8'h22, 8'h33, 8'h44, 512, 8, 8, 1);
    run_cmd("R9 inject chs", 1, 8'h05, 8'h09, 8'h40, 8'h01, 1024, 32, 8, 1);
    advance("R7 advance after inject");

    repeat (5) @(negedge clk);
    chk("R9 scoreboard drained", longint'(sb.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule